// File: doc/BRIEF.md
# Two-Channel Chaining Word Mover

This block moves 32-bit words between locations on a shared memory bus on behalf of two independent channels. Each channel holds a read pointer, a write pointer, a programmed word count and a small control word. A channel starts when one of its trigger registers is written. Each channel reaches its four registers through four windows, and each window lists the registers in a different order. The last word of every window is the trigger for that window. A producer can therefore load any tail of registers and start the channel with a single burst.

When a channel moves its last word, it can start the other channel on the same clock edge and set its own completion flag. A write pointer whose top bit is set refers to the block's own register port instead of memory. One channel can therefore read a list of short descriptors from memory and write them into the other channel's trigger window. The two channels then walk a gather list together with no processor involvement. A descriptor with a zero count stops the walk and flags completion.

Top module: `dma_chain_pair`

## Requirements
- R1: The register port takes a 6-bit word address. When bit 5 is 0, bit 4 selects the channel, bits 3:2 select a window and bits 1:0 select a slot. Slot 3 of every window is a trigger. The windows list the registers in slot order 0..3 as follows. Window 0: read, write, count, control. Window 1: control, read, write, count. Window 2: control, count, read, write. Window 3: control, write, count, read.
- R2: Control word fields: bit 0 advances the read pointer, bit 1 advances the write pointer, bit 2 names the chain target channel, and bit 3 restores the write pointer at block end. A chain target equal to the channel's own index means no chaining.
- R3: A started channel moves exactly its programmed count of words. Each word is read at the read pointer and then written at the write pointer. Each pointer advances by 4 after every word when its advance bit is set.
- R4: Registers left out of a trigger burst keep their values. Pointers keep their advanced values, and the programmed count is reused at every start.
- R5: A write pointer with bit ADDR_W-1 set directs the word to the register port at word address pointer[7:2] instead of to memory. Such an internal write takes precedence over an external write in the same cycle.
- R6: On the edge where a channel's last word completes, its busy flag clears and its chain target starts. The target is busy on the very next cycle.
- R7: Completion sets a per-channel status bit on the same edge. The irq output is the OR of status ANDed with the enable bits. Status is at global address 32 (bit 5 set, low bits 0) and is cleared by writing 1. The enables are at address 33.
- R8: Every register write aimed at a busy channel is dropped. A trigger aimed at a busy channel also sets that channel's sticky err bit. The err bits are cleared by writing 1 at address 34.
- R9: A trigger whose effective count is zero does not start the channel, causes no bus activity and sets that channel's status bit.
- R10: When both channels are busy, each word slot is granted to channel 0.
- R11: With control bit 3 set, the write pointer returns at block end to its value at the start of the block.
- R12: After reset, busy, err, irq and mem_req are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register port write strobe |
| cfg_addr | input | 6 | Register port word address |
| cfg_wdata | input | DATA_W | Register port write data |
| mem_req | output | 1 | Memory bus request |
| mem_we | output | 1 | Memory write (else read) |
| mem_addr | output | ADDR_W | Memory byte address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_rdata | input | DATA_W | Read data, valid the cycle after a read request |
| busy | output | 2 | Per-channel busy |
| err | output | 2 | Per-channel sticky trigger-while-busy flag |
| irq | output | 1 | Masked completion interrupt |

## Verification
The bench builds the block with its defaults: 16-bit addresses, 16-bit counts and 32-bit words. This places the register window at address bit 15, so a real descriptor gather, with one channel writing into the other's count and read-trigger slots, fits beside a 1 KB memory model. Random copies on both channels cover varied lengths and offsets. Directed cases cover the edge-exact chain handoff, priority between overlapping channels, null descriptors, masking and the sticky error.

// File: rtl/dma_pkg.sv
package dma_pkg;
  localparam int NUM_CH = 2;
  localparam int CTRL_W = 4;
  localparam int RADDR_W = 6;

  typedef enum logic [1:0] {SEL_RD, SEL_WR, SEL_CNT, SEL_CTRL} reg_sel_e;
  typedef enum logic [1:0] {ST_ARB, ST_RD, ST_WR} seq_state_e;

  typedef struct packed {
    logic wr_reload;
    logic chain_to;
    logic wr_inc;
    logic rd_inc;
  } ctrl_t;

  // Window/slot to register; slot 3 is always the trigger
  function automatic reg_sel_e alias_sel(input logic [1:0] grp, input logic [1:0] slot);
    reg_sel_e s;
    case ({grp, slot})
      4'b00_00: s = SEL_RD;
      4'b00_01: s = SEL_WR;
      4'b00_10: s = SEL_CNT;
      4'b00_11: s = SEL_CTRL;
      4'b01_01: s = SEL_RD;
      4'b01_10: s = SEL_WR;
      4'b01_11: s = SEL_CNT;
      4'b10_01: s = SEL_CNT;
      4'b10_10: s = SEL_RD;
      4'b10_11: s = SEL_WR;
      4'b11_01: s = SEL_WR;
      4'b11_10: s = SEL_CNT;
      4'b11_11: s = SEL_RD;
      default:  s = SEL_CTRL;
    endcase
    return s;
  endfunction
endpackage

// File: rtl/dma_channel.sv
module dma_channel
  import dma_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  reg_sel_e          wr_sel,
  input  logic              wr_trig,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              chain_in,
  input  logic              step,
  input  logic              err_clr,
  output logic              busy,
  output logic [ADDR_W-1:0] rd_addr,
  output logic [ADDR_W-1:0] wr_addr,
  output ctrl_t             ctrl,
  output logic              done,
  output logic              null_done,
  output logic              err
);
  localparam logic [ADDR_W-1:0] STRIDE = ADDR_W'(4);
  localparam logic [CNT_W-1:0]  ONE    = CNT_W'(1);

  logic [CNT_W-1:0]  cnt_cfg, cnt_left, cnt_eff;
  logic [ADDR_W-1:0] wr_base, wr_eff;
  logic              wr_ok, trig, start;

  assign wr_ok     = wr_en & ~busy;
  assign trig      = (wr_en & wr_trig) | chain_in;
  assign cnt_eff   = (wr_ok && wr_sel == SEL_CNT) ? wr_data[CNT_W-1:0] : cnt_cfg;
  assign wr_eff    = (wr_ok && wr_sel == SEL_WR) ? wr_data[ADDR_W-1:0] : wr_addr;
  assign done      = step & busy & (cnt_left == ONE);
  assign null_done = trig & ~busy & (cnt_eff == '0);
  assign start     = trig & ~busy & (cnt_eff != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy     <= 1'b0;
      rd_addr  <= '0;
      wr_addr  <= '0;
      wr_base  <= '0;
      cnt_cfg  <= '0;
      cnt_left <= '0;
      ctrl     <= '0;
      err      <= 1'b0;
    end else begin
      if (wr_ok) begin
        case (wr_sel)
          SEL_RD:  rd_addr <= wr_data[ADDR_W-1:0];
          SEL_WR:  wr_addr <= wr_data[ADDR_W-1:0];
          SEL_CNT: cnt_cfg <= wr_data[CNT_W-1:0];
          default: ctrl    <= ctrl_t'(wr_data[CTRL_W-1:0]);
        endcase
      end
      if (step && busy) begin
        cnt_left <= cnt_left - ONE;
        if (ctrl.rd_inc) rd_addr <= rd_addr + STRIDE;
        if (ctrl.wr_inc) wr_addr <= wr_addr + STRIDE;
        if (cnt_left == ONE) begin
          busy <= 1'b0;
          if (ctrl.wr_reload) wr_addr <= wr_base;
        end
      end
      if (start) begin
        busy     <= 1'b1;
        cnt_left <= cnt_eff;
        wr_base  <= wr_eff;
      end
      if (err_clr) err <= 1'b0;
      if (trig && busy) err <= 1'b1;
    end
  end

  assert_busy_trig_flags_R8: assert property (@(posedge clk) disable iff (rst)
    (trig && busy) |=> err);
  assert_word_countdown_R3: assert property (@(posedge clk) disable iff (rst)
    (step && busy && !done) |=> (busy && cnt_left == $past(cnt_left) - ONE));
  assert_null_stays_idle_R9: assert property (@(posedge clk) disable iff (rst)
    null_done |=> !busy);
endmodule

// File: rtl/dma_seq.sv
module dma_seq
  import dma_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_CH-1:0]  req,
  input  logic [ADDR_W-1:0]  rd_addr [NUM_CH],
  input  logic [ADDR_W-1:0]  wr_addr [NUM_CH],
  output logic               mem_req,
  output logic               mem_we,
  output logic [ADDR_W-1:0]  mem_addr,
  output logic [DATA_W-1:0]  mem_wdata,
  input  logic [DATA_W-1:0]  mem_rdata,
  output logic [NUM_CH-1:0]  step,
  output logic               eng_we,
  output logic [RADDR_W-1:0] eng_addr,
  output logic [DATA_W-1:0]  eng_data
);
  seq_state_e  state;
  logic        grant;
  logic        reg_space;
  logic [ADDR_W-1:0] cur_wr;

  assign cur_wr    = wr_addr[grant];
  assign reg_space = cur_wr[ADDR_W-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_ARB;
      grant <= 1'b0;
    end else begin
      case (state)
        ST_ARB: if (|req) begin
          grant <= ~req[0];
          state <= ST_RD;
        end
        ST_RD:   state <= ST_WR;
        default: state <= ST_ARB;
      endcase
    end
  end

  always_comb begin
    mem_req   = (state == ST_RD) || (state == ST_WR && !reg_space);
    mem_we    = (state == ST_WR) && !reg_space;
    mem_addr  = (state == ST_RD) ? rd_addr[grant] : cur_wr;
    mem_wdata = mem_rdata;
    eng_we    = (state == ST_WR) && reg_space;
    eng_addr  = cur_wr[RADDR_W+1:2];
    eng_data  = mem_rdata;
    step      = '0;
    if (state == ST_WR) step[grant] = 1'b1;
  end

  assert_low_channel_wins_R10: assert property (@(posedge clk) disable iff (rst)
    (state == ST_ARB && req == 2'b11) |=> (state == ST_RD && grant == 1'b0));
  assert_read_before_write_R3: assert property (@(posedge clk) disable iff (rst)
    (state == ST_RD) |=> (state == ST_WR));
endmodule

// File: rtl/dma_irq.sv
module dma_irq #(
  parameter int NCH = 2
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [NCH-1:0] set,
  input  logic           clr_we,
  input  logic [NCH-1:0] clr_bits,
  input  logic           en_we,
  input  logic [NCH-1:0] en_bits,
  output logic           irq
);
  logic [NCH-1:0] status, en, status_nx, en_nx;

  always_comb begin
    status_nx = (status & ~(clr_we ? clr_bits : '0)) | set;
    en_nx     = en_we ? en_bits : en;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      status <= '0;
      en     <= '0;
      irq    <= 1'b0;
    end else begin
      status <= status_nx;
      en     <= en_nx;
      irq    <= |(status_nx & en_nx);
    end
  end

  assert_done_latched_R7: assert property (@(posedge clk) disable iff (rst)
    (|set) |=> ((status & $past(set)) == $past(set)));
endmodule

// File: rtl/dma_chain_pair.sv
module dma_chain_pair
  import dma_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [5:0]        cfg_addr,
  input  logic [DATA_W-1:0] cfg_wdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [1:0]        busy,
  output logic [1:0]        err,
  output logic              irq
);
  logic [ADDR_W-1:0]  rd_addr [NUM_CH];
  logic [ADDR_W-1:0]  wr_addr [NUM_CH];
  ctrl_t              ctrl    [NUM_CH];
  logic [NUM_CH-1:0]  done, null_done, chain_in, step, ch_hit;
  logic               eng_we, p_we, glob;
  logic [RADDR_W-1:0] eng_addr, p_addr;
  logic [DATA_W-1:0]  eng_data, p_data;
  reg_sel_e           p_sel;

  // Internal register writes from the engine take the port first
  assign p_we   = eng_we | cfg_we;
  assign p_addr = eng_we ? eng_addr : cfg_addr;
  assign p_data = eng_we ? eng_data : cfg_wdata;
  assign p_sel  = alias_sel(p_addr[3:2], p_addr[1:0]);
  assign glob   = p_we & p_addr[5];

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    always_comb begin
      chain_in[i] = 1'b0;
      for (int j = 0; j < NUM_CH; j++)
        if (j != i && done[j] && ctrl[j].chain_to == 1'(i)) chain_in[i] = 1'b1;
    end
    assign ch_hit[i] = p_we & ~p_addr[5] & (p_addr[4] == 1'(i));

    dma_channel #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .DATA_W(DATA_W)) u_ch (
      .clk(clk), .rst(rst),
      .wr_en(ch_hit[i]), .wr_sel(p_sel), .wr_trig(p_addr[1:0] == 2'b11),
      .wr_data(p_data), .chain_in(chain_in[i]), .step(step[i]),
      .err_clr(glob && p_addr[4:0] == 5'd2 && p_data[i]),
      .busy(busy[i]), .rd_addr(rd_addr[i]), .wr_addr(wr_addr[i]),
      .ctrl(ctrl[i]), .done(done[i]), .null_done(null_done[i]), .err(err[i])
    );
  end

  dma_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
    .clk(clk), .rst(rst), .req(busy), .rd_addr(rd_addr), .wr_addr(wr_addr),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .step(step),
    .eng_we(eng_we), .eng_addr(eng_addr), .eng_data(eng_data)
  );

  dma_irq #(.NCH(NUM_CH)) u_irq (
    .clk(clk), .rst(rst), .set(done | null_done),
    .clr_we(glob && p_addr[4:0] == 5'd0), .clr_bits(p_data[NUM_CH-1:0]),
    .en_we(glob && p_addr[4:0] == 5'd1), .en_bits(p_data[NUM_CH-1:0]),
    .irq(irq)
  );

  assert_done_releases_R6: assert property (@(posedge clk) disable iff (rst)
    (done[0] && !chain_in[0]) |=> !busy[0]);
  assert_chain_hands_over_R6: assert property (@(posedge clk) disable iff (rst)
    (chain_in[1] && !busy[1] && !null_done[1]) |=> busy[1]);
  assert_single_bus_owner_R10: assert property (@(posedge clk) disable iff (rst)
    $onehot0(step));
endmodule

// File: tb/test_dma_chain_pair.sv
module test_dma_chain_pair;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 16;
  localparam int DATA_W = 32;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              cfg_we = 1'b0;
  logic [5:0]        cfg_addr = '0;
  logic [DATA_W-1:0] cfg_wdata = '0;
  logic              mem_req, mem_we, irq;
  logic [ADDR_W-1:0] mem_addr;
  logic [DATA_W-1:0] mem_wdata;
  logic [DATA_W-1:0] mem_rdata;
  logic [1:0]        busy, err;

  logic [DATA_W-1:0] mem  [0:255];
  logic [ADDR_W-1:0] wlog [0:255];
  int                wcnt = 0;
  logic              ld_we = 1'b0;
  logic [7:0]        ld_idx = '0;
  logic [DATA_W-1:0] ld_dat = '0;

  int n_chk = 0, n_fail = 0, cyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_chain_pair i_dma_chain_pair (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .busy(busy), .err(err), .irq(irq)
  );

  // Memory model: 1 KB, one cycle read latency, bench load port
  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 256; i++) mem[i] <= $urandom;
      mem_rdata <= '0;
    end else begin
      if (ld_we) mem[ld_idx] <= ld_dat;
      if (mem_req && mem_we) begin
        mem[mem_addr[9:2]] <= mem_wdata;
        wlog[wcnt[7:0]]    <= mem_addr;
        wcnt               <= wcnt + 1;
      end
      if (mem_req && !mem_we) mem_rdata <= mem[mem_addr[9:2]];
    end
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected<150000", cyc);
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // All tasks start and end at a falling edge
  task automatic cfg_wr(input logic [5:0] a, input logic [31:0] d);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic ch_wr(input int ch, input int grp, input int slot, input logic [31:0] d);
    cfg_wr({1'b0, 1'(ch), 2'(grp), 2'(slot)}, d);
  endtask

  task automatic mem_ld(input int idx, input logic [31:0] d);
    ld_we = 1'b1; ld_idx = 8'(idx); ld_dat = d;
    @(negedge clk);
    ld_we = 1'b0;
  endtask

  task automatic wait_idle();
    for (int k = 0; k < 3000; k++) begin
      if (busy == 2'b00) break;
      @(negedge clk);
    end
  endtask

  function automatic logic [31:0] ctrl_word(input bit rinc, input bit winc, input int chain, input bit rel);
    return {28'd0, rel, 1'(chain), winc, rinc};
  endfunction

  initial begin
    int w0, n, s, d, ch;
    bit seen;
    void'($urandom(32'h1234_5eed));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R12 reset state
    chk("R12 busy", busy, 0);
    chk("R12 err", err, 0);
    chk("R12 irq", irq, 0);
    chk("R12 mem_req", mem_req, 0);

    cfg_wr(6'd33, 3);

    // R1 R3 random copies through window 0
    for (int it = 0; it < 10; it++) begin
      ch = $urandom_range(0, 1);
      n  = $urandom_range(1, 5);
      s  = $urandom_range(0, 50);
      d  = 128 + it * 6;
      w0 = wcnt;
      ch_wr(ch, 0, 0, s * 4);
      ch_wr(ch, 0, 1, d * 4);
      ch_wr(ch, 0, 2, n);
      ch_wr(ch, 0, 3, ctrl_word(1, 1, ch, 0));
      wait_idle();
      chk("R3 word count", wcnt - w0, n);
      for (int k = 0; k < n; k++) chk("R3 copied word", mem[d + k], mem[s + k]);
      chk("R7 irq after block", irq, 1);
      cfg_wr(6'd32, 3);
      chk("R7 irq cleared", irq, 0);
    end

    // R2 R1 fixed source via window 2 (write-pointer trigger)
    ch_wr(1, 2, 0, ctrl_word(0, 1, 1, 0));
    ch_wr(1, 2, 1, 3);
    ch_wr(1, 2, 2, 17 * 4);
    ch_wr(1, 2, 3, 192 * 4);
    wait_idle();
    for (int k = 0; k < 3; k++) chk("R2 fixed read pointer", mem[192 + k], mem[17]);

    // R4 only count and read-trigger through window 3
    ch_wr(1, 3, 2, 2);
    ch_wr(1, 3, 3, 20 * 4);
    wait_idle();
    chk("R4 kept write pointer a", mem[195], mem[20]);
    chk("R4 kept write pointer b", mem[196], mem[20]);
    cfg_wr(6'd32, 3);

    // R8 trigger while busy
    w0 = wcnt;
    ch_wr(0, 0, 0, 16 * 4);
    ch_wr(0, 0, 1, 208 * 4);
    ch_wr(0, 0, 2, 4);
    ch_wr(0, 0, 3, ctrl_word(1, 1, 0, 0));
    ch_wr(0, 1, 3, 9);
    chk("R8 err set", err, 2'b01);
    wait_idle();
    chk("R8 busy write dropped", wcnt - w0, 4);
    cfg_wr(6'd34, 1);
    chk("R8 err cleared", err, 0);
    cfg_wr(6'd32, 3);

    // R7 masking: pending status shows once enabled
    cfg_wr(6'd33, 2);
    ch_wr(0, 0, 2, 1);
    ch_wr(0, 0, 3, ctrl_word(1, 1, 0, 0));
    wait_idle();
    @(negedge clk);
    chk("R7 masked irq", irq, 0);
    cfg_wr(6'd33, 3);
    chk("R7 unmasked pending", irq, 1);
    cfg_wr(6'd32, 3);

    // R9 zero count
    w0 = wcnt;
    ch_wr(0, 0, 2, 0);
    ch_wr(0, 0, 3, ctrl_word(1, 1, 0, 0));
    chk("R9 no start", busy, 0);
    chk("R9 irq", irq, 1);
    repeat (4) @(negedge clk);
    chk("R9 no bus writes", wcnt - w0, 0);
    cfg_wr(6'd32, 3);

    // R6 chain handoff: ch0 -> ch1, ch1 not chained
    cfg_wr(6'd33, 1);
    ch_wr(1, 1, 0, ctrl_word(1, 1, 1, 0));
    ch_wr(1, 1, 1, 24 * 4);
    ch_wr(1, 1, 2, 224 * 4);
    ch_wr(1, 0, 2, 2);
    ch_wr(0, 0, 0, 28 * 4);
    ch_wr(0, 0, 1, 232 * 4);
    ch_wr(0, 0, 2, 3);
    ch_wr(0, 0, 3, ctrl_word(1, 1, 1, 0));
    seen = 0;
    for (int k = 0; k < 200 && !seen; k++) begin
      logic prev;
      prev = busy[0];
      @(negedge clk);
      if (prev && !busy[0]) begin
        seen = 1;
        chk("R6 target busy next cycle", busy[1], 1);
        chk("R7 irq with handoff", irq, 1);
      end
    end
    chk("R6 handoff seen", seen, 1);
    wait_idle();
    for (int k = 0; k < 3; k++) chk("R6 first block", mem[232 + k], mem[28 + k]);
    for (int k = 0; k < 2; k++) chk("R6 chained block", mem[224 + k], mem[24 + k]);
    cfg_wr(6'd32, 3);

    // R10 priority: ch0 keeps every slot while busy
    ch_wr(1, 1, 0, ctrl_word(1, 1, 1, 0));
    ch_wr(1, 1, 1, 32 * 4);
    ch_wr(1, 1, 2, 240 * 4);
    ch_wr(0, 0, 0, 36 * 4);
    ch_wr(0, 0, 1, 244 * 4);
    ch_wr(0, 0, 2, 3);
    w0 = wcnt;
    ch_wr(0, 0, 3, ctrl_word(1, 1, 0, 0));
    ch_wr(1, 1, 3, 2);
    wait_idle();
    for (int k = 0; k < 3; k++) chk("R10 ch0 first", wlog[w0 + k], 16'((244 + k) * 4));
    for (int k = 0; k < 2; k++) chk("R10 ch1 after", wlog[w0 + 3 + k], 16'((240 + k) * 4));
    cfg_wr(6'd32, 3);

    // R5 R11 gather: ch0 streams {count, read} pairs into ch1 window 3
    mem_ld(96, 2);  mem_ld(97, 18 * 4);
    mem_ld(98, 3);  mem_ld(99, 22 * 4);
    mem_ld(100, 1); mem_ld(101, 26 * 4);
    mem_ld(102, 0); mem_ld(103, 0);
    cfg_wr(6'd33, 2);
    ch_wr(1, 1, 0, ctrl_word(1, 1, 0, 0));
    ch_wr(1, 1, 2, 248 * 4);
    ch_wr(0, 0, 0, 96 * 4);
    ch_wr(0, 0, 1, 32'h8078);
    ch_wr(0, 0, 2, 2);
    w0 = wcnt;
    ch_wr(0, 0, 3, ctrl_word(1, 1, 0, 1));
    for (int k = 0; k < 20; k++) wait_idle();
    chk("R5 only data words on bus", wcnt - w0, 6);
    chk("R5 gather w0", mem[248], mem[18]);
    chk("R5 gather w1", mem[249], mem[19]);
    chk("R11 gather w2", mem[250], mem[22]);
    chk("R11 gather w3", mem[251], mem[23]);
    chk("R11 gather w4", mem[252], mem[24]);
    chk("R11 gather w5", mem[253], mem[26]);
    chk("R9 terminal irq", irq, 1);
    chk("R8 no error in gather", err, 0);

    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule